// File: doc/BRIEF.md
# Suspendable Flash Erase Pulse Sequencer

This block models the engine that erases one flash sector. An erase is a series of fixed-length pulses, and time is counted in clock ticks. The sector is clean once a parameter-set number of pulses has run to completion. Software can pause a running erase with a suspend command to read the array, then continue it with a resume command. While paused, the block raises a read-permission flag and the erase makes no headway.

Progress is counted only in whole pulses. When a suspend lands part way through a pulse, the ticks that pulse has already spent are thrown away, and on resume that pulse starts again from tick zero. As a result, frequent suspends stretch the total erase time. Each erase also keeps a count of its suspends. When the limit check is enabled and the count goes past a parameter limit, the erase stops in a fault state. A fresh erase command clears the fault and the count and starts over.

Top module: `erase_pulse_sequencer`

## Requirements
- R1: While reset is held and after it is released, busy, suspended, read_ok, done and fail are all low.
- R2: An erase command accepted from idle raises busy from the next cycle. If there are no suspends, done is high for exactly one cycle, N_PULSES*PULSE_TICKS cycles after the command edge. In that same cycle busy is low and the block is idle.
- R3: Only completed pulses count toward N_PULSES. A suspend taken on the same edge on which a pulse would complete wins over that completion, and the pulse is not counted.
- R4: While suspended, suspended, read_ok and busy are high, done stays low, and no erase progress is made for any length of hold.
- R5: A resume restarts the interrupted pulse from zero. After a resume at edge r with k pulses already complete, done rises (N_PULSES-k)*PULSE_TICKS cycles after r.
- R6: A suspend is ignored unless an erase is running. A resume is ignored unless the block is suspended. This includes the idle and fault states.
- R7: An erase command issued while an erase is running or suspended is ignored and does not change its timing.
- R8: With the limit check enabled, the suspend that would make the per-erase count exceed SUSP_LIMIT sends the block to a fault state. In that state fail is high and busy, suspended and read_ok are low.
- R9: An erase command in the fault state clears fail and the suspend count and starts a normal erase, which then accepts up to SUSP_LIMIT suspends again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick of erase time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_cmd | input | 1 | Start a sector erase (one-cycle strobe) |
| suspend_cmd | input | 1 | Pause the running erase |
| resume_cmd | input | 1 | Continue a paused erase |
| busy | output | 1 | Erase running or suspended |
| suspended | output | 1 | Erase is paused |
| read_ok | output | 1 | Array may be read (only while paused) |
| done | output | 1 | One-cycle strobe when the last pulse completes |
| fail | output | 1 | Erase aborted by the suspend limit; held until a new erase |

## Verification
Suppose the block keeps part of a discarded pulse, or misses a completed one. Then nothing odd appears at the suspend itself, but done moves off its computed edge by up to a full pulse at the end of the erase. The scoreboard therefore predicts the exact done edge from the recorded command edges. A suspend count that is not cleared, or is off by one, shows up one suspend early or late as a fail rising on the wrong edge, or as a fail that never rises. Ignored commands that leak through show up one cycle later in the suspended, busy or fail flags.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [1:0] {
        ES_IDLE  = 2'd0,
        ES_RUN   = 2'd1,
        ES_HOLD  = 2'd2,
        ES_FAULT = 2'd3
    } es_state_t;

endpackage

// File: rtl/erase_tick_timer.sv
module erase_tick_timer #(
    parameter int PULSE_TICKS = 16,
    localparam int TW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic          pulse_end,
    output logic [TW-1:0] tick
);

    localparam logic [TW-1:0] LAST = TW'(PULSE_TICKS - 1);

    logic [TW-1:0] tick_d, tick_q;

    always_comb begin
        tick_d = tick_q;
        if (clr) begin
            tick_d = '0;
        end else if (en) begin
            tick_d = (tick_q == LAST) ? '0 : tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    assign pulse_end = en && !clr && (tick_q == LAST);
    assign tick      = tick_q;

endmodule

// File: rtl/erase_pulse_tally.sv
module erase_pulse_tally #(
    parameter int N_PULSES = 8,
    localparam int CW = $clog2(N_PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic          last,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] FINAL = CW'(N_PULSES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last  = (cnt_q == FINAL);
    assign count = cnt_q;

endmodule

// File: rtl/erase_suspend_guard.sv
module erase_suspend_guard #(
    parameter int SUSP_LIMIT = 5680,
    parameter bit LIMIT_EN   = 1'b1,
    localparam int SW = $clog2(SUSP_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam logic [SW-1:0] CAP = SW'(SUSP_LIMIT);

    logic [SW-1:0] sus_d, sus_q;

    always_comb begin
        sus_d = sus_q;
        if (clr)                      sus_d = '0;
        else if (inc && sus_q != CAP) sus_d = sus_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sus_q <= '0;
        else        sus_q <= sus_d;
    end

    generate
        if (LIMIT_EN) begin : g_limit
            assign at_limit = (sus_q == CAP);
        end else begin : g_nolimit
            assign at_limit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/erase_pulse_sequencer.sv
module erase_pulse_sequencer
    import erase_seq_pkg::*;
#(
    parameter int PULSE_TICKS = 16,
    parameter int N_PULSES    = 8,
    parameter int SUSP_LIMIT  = 5680,
    parameter bit LIMIT_EN    = 1'b1,
    localparam int TW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1,
    localparam int CW = $clog2(N_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_cmd,
    input  logic suspend_cmd,
    input  logic resume_cmd,
    output logic busy,
    output logic suspended,
    output logic read_ok,
    output logic done,
    output logic fail
);

    typedef struct packed {
        es_state_t state;
        logic      done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          start, susp_acc, res_acc, run;
    logic          pulse_end, last_pulse, at_limit;
    logic [TW-1:0] tick;
    logic [CW-1:0] pulse_count;

    always_comb begin
        start    = erase_cmd && (seq_q.state == ES_IDLE || seq_q.state == ES_FAULT);
        susp_acc = suspend_cmd && (seq_q.state == ES_RUN);
        res_acc  = resume_cmd && (seq_q.state == ES_HOLD);
        run      = (seq_q.state == ES_RUN) && !suspend_cmd;
    end

    erase_tick_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start || susp_acc || res_acc),
        .en        (run),
        .pulse_end (pulse_end),
        .tick      (tick)
    );

    erase_pulse_tally #(.N_PULSES(N_PULSES)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .inc   (pulse_end),
        .last  (last_pulse),
        .count (pulse_count)
    );

    erase_suspend_guard #(.SUSP_LIMIT(SUSP_LIMIT), .LIMIT_EN(LIMIT_EN)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .inc      (susp_acc),
        .at_limit (at_limit)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ES_IDLE, ES_FAULT: begin
                if (start) seq_d.state = ES_RUN;
            end
            ES_RUN: begin
                if (susp_acc) begin
                    seq_d.state = at_limit ? ES_FAULT : ES_HOLD;
                end else if (pulse_end && last_pulse) begin
                    seq_d.state = ES_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            ES_HOLD: begin
                if (res_acc) seq_d.state = ES_RUN;
            end
            default: seq_d.state = ES_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ES_IDLE;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.state == ES_RUN) || (seq_q.state == ES_HOLD);
    assign suspended = (seq_q.state == ES_HOLD);
    assign read_ok   = (seq_q.state == ES_HOLD);
    assign fail      = (seq_q.state == ES_FAULT);
    assign done      = seq_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !fail));  // R2
    AST_SUSPEND_NO_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !suspended && suspend_cmd) |=> $stable(pulse_count));  // R3
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !resume_cmd) |=> ($stable(pulse_count) && tick == '0 && !done));  // R4
    AST_RESUME_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && resume_cmd) |=> (tick == '0 && busy && !suspended));  // R5
    AST_IDLE_SUSPEND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && suspend_cmd && !erase_cmd) |=> !suspended);  // R6
    AST_HOLD_ERASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && erase_cmd && !resume_cmd) |=> suspended);  // R7
    AST_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !suspended && suspend_cmd && at_limit) |=> (fail && !read_ok));  // R8
    AST_FAULT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && erase_cmd) |=> (!fail && busy && pulse_count == '0));  // R9

endmodule

// File: tb/erase_pulse_sequencer_test.sv
`timescale 1ns/1ps
module erase_pulse_sequencer_test;

    localparam int P   = 4;
    localparam int N   = 3;
    localparam int LIM = 3;
    localparam int SEL_ERA = 0;
    localparam int SEL_SUS = 1;
    localparam int SEL_RES = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic erase_cmd = 1'b0, suspend_cmd = 1'b0, resume_cmd = 1'b0;
    logic busy, suspended, read_ok, done, fail;

    always #4 clk = ~clk;

    erase_pulse_sequencer #(
        .PULSE_TICKS(P), .N_PULSES(N), .SUSP_LIMIT(LIM), .LIMIT_EN(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .erase_cmd(erase_cmd),
        .suspend_cmd(suspend_cmd), .resume_cmd(resume_cmd),
        .busy(busy), .suspended(suspended), .read_ok(read_ok),
        .done(done), .fail(fail)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int kind; int edge_no; } exp_t;
    exp_t expq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic issue(input int sel, output int e);
        case (sel)
            SEL_ERA: erase_cmd   = 1'b1;
            SEL_SUS: suspend_cmd = 1'b1;
            default: resume_cmd  = 1'b1;
        endcase
        @(posedge clk);
        @(negedge clk);
        erase_cmd = 1'b0; suspend_cmd = 1'b0; resume_cmd = 1'b0;
        e = cyc;
    endtask

    // monitor: compare done strobes and fail rises against the expectation queue
    logic fail_prev = 1'b0;
    always @(negedge clk) begin
        int kind;
        exp_t it;
        if (rst_n) begin
            if (done || (fail && !fail_prev)) begin
                kind = done ? 0 : 1;
                if (expq.size() == 0) begin
                    check(1'b0, kind == 0 ? "R2" : "R8", "unexpected event at edge", cyc, -1);
                end else begin
                    it = expq.pop_front();
                    check(it.kind == kind, "R3", "event kind", kind, it.kind);
                    check(it.edge_no == cyc, it.kind == 0 ? "R5" : "R8", "event edge",
                          cyc, it.edge_no);
                end
            end
            fail_prev <= fail;
        end
    end

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 3000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 3000", cyc);
            summary_and_end();
        end
    end

    initial begin
        int e0, s, r, seg, dp;

        // R1: reset state
        repeat (3) @(negedge clk);
        check({busy, suspended, read_ok, done, fail} == 5'b0, "R1", "status during reset",
              {busy, suspended, read_ok, done, fail}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy, suspended, read_ok, done, fail} == 5'b0, "R1", "status after reset",
              {busy, suspended, read_ok, done, fail}, 0);

        // R2: plain erase
        issue(SEL_ERA, e0);
        expq.push_back('{0, e0 + N * P});
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        repeat (N * P) @(negedge clk);
        check(busy == 1'b0, "R2", "busy in done cycle", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R2", "done width", done, 0);

        // R6: suspend and resume while idle
        issue(SEL_SUS, s);
        check(suspended == 1'b0 && read_ok == 1'b0, "R6", "idle suspend", suspended, 0);
        issue(SEL_RES, r);
        check(busy == 1'b0, "R6", "idle resume", busy, 0);

        // R4/R5/R6/R7: mid-pulse suspend with ignored commands around it
        issue(SEL_ERA, e0);
        seg = e0; dp = 0;
        @(negedge clk);
        issue(SEL_RES, r);
        check(suspended == 1'b0, "R6", "resume while running", suspended, 0);
        issue(SEL_ERA, r);
        check(busy == 1'b1 && suspended == 1'b0, "R7", "erase while running", busy, 1);
        repeat (2) @(negedge clk);
        issue(SEL_SUS, s);
        dp += (s - seg - 1) / P;
        check(suspended && read_ok && busy, "R4", "suspended flags",
              {suspended, read_ok, busy}, 7);
        issue(SEL_ERA, r);
        check(suspended == 1'b1, "R7", "erase while suspended", suspended, 1);
        repeat (6) @(negedge clk);
        check(suspended && read_ok && !done, "R4", "long hold", {suspended, read_ok, done}, 6);
        issue(SEL_RES, r);
        seg = r;
        expq.push_back('{0, seg + (N - dp) * P});
        check(!suspended && !read_ok && busy, "R5", "after resume",
              {suspended, read_ok, busy}, 1);
        repeat ((N - dp) * P) @(negedge clk);
        check(busy == 1'b0, "R5", "idle after resumed erase", busy, 0);

        // R3: suspend on the edge a pulse would complete
        issue(SEL_ERA, e0);
        seg = e0; dp = 0;
        repeat (P - 1) @(negedge clk);
        issue(SEL_SUS, s);
        dp += (s - seg - 1) / P;
        check(dp == 0 && suspended, "R3", "boundary suspend taken", suspended, 1);
        issue(SEL_RES, r);
        seg = r;
        expq.push_back('{0, seg + (N - dp) * P});
        repeat ((N - dp) * P) @(negedge clk);
        check(busy == 1'b0, "R3", "boundary pulse not credited", busy, 0);

        // R8: exceed the suspend limit
        issue(SEL_ERA, e0);
        for (int i = 0; i < LIM; i++) begin
            issue(SEL_SUS, s);
            issue(SEL_RES, r);
        end
        expq.push_back('{1, cyc + 1});
        issue(SEL_SUS, s);
        check(fail && !busy && !read_ok && !suspended, "R8", "fault flags",
              {fail, busy, read_ok, suspended}, 8);
        issue(SEL_RES, r);
        check(fail && !busy, "R6", "resume in fault", {fail, busy}, 2);

        // R9: restart clears fault and suspend count
        issue(SEL_ERA, e0);
        check(!fail && busy, "R9", "restart from fault", {fail, busy}, 1);
        seg = e0;
        for (int i = 0; i < LIM; i++) begin
            issue(SEL_SUS, s);
            issue(SEL_RES, r);
            seg = r;
        end
        check(!fail && busy, "R9", "limit suspends accepted", {fail, busy}, 1);
        expq.push_back('{0, seg + N * P});
        repeat (N * P) @(negedge clk);
        check(busy == 1'b0 && fail == 1'b0, "R9", "retried erase completes", {busy, fail}, 0);

        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R2", "pending expected events", expq.size(), 0);
        summary_and_end();
    end

endmodule